// File: doc/BRIEF.md
# Near-Bank Multiply-Accumulate Unit Array

This block is the array of compute units that sits beside the DRAM banks of one memory device. Each unit owns a signed accumulator and a small local buffer, and on every cycle of a compute command it takes one column word as its first operand from a bank it is wired to. It multiplies that word lane by lane with a second operand and adds the lane sum into its accumulator. The word is a vector of signed byte lanes. The second operand comes from another of the unit's banks, from its own local buffer, or from a device-wide global buffer that feeds the same word to every unit.

A connection mode, given by the number of active units in each command, sets the fan-in. With N active units out of a bank count B, unit u reaches the B/N adjacent banks starting at bank u·B/N, and a bank selector in the command picks one of them. Only counts from a configured set of divisors of B are accepted. A per-command unit mask lets only some active units compute. Register moves copy accumulators into a local-buffer slot and load them back, so that partial sums can be parked and resumed. A fill port loads operand words into the local buffers or the global buffer. Bank reads arrive as already-read column words: the block publishes the column it wants from each bank and samples that bank's data bus in the same cycle.

Top module: `nbmac_array`

## Requirements
- R1: After reset every accumulator reads zero, and `busy` and `err` are low.
- R2: With `cmd_units` = N accepted, unit u reads its operands from bank u·(NBANK/N) + selector, and units with index ≥ N hold their accumulators whatever their mask bit.
- R3: If `op1_sel` differs from `op2_sel`, both operands come from the unit's banks, and the accumulator gains the sum over lanes of the signed products; lane j is bits [8j+7:8j] of a column word.
- R4: If the selectors are equal and `op2_row` is zero, the second operand is the low COLW bits of the unit's local-buffer entry at (`op2_col` + i) mod BUF_DEPTH for column step i.
- R5: If the selectors are equal and `op2_row` is nonzero, the second operand is global-buffer entry (`op2_col` + i) mod BUF_DEPTH, the same word for all units.
- R6: An accepted command with `cmd_ncol` = n keeps `busy` high for exactly n cycles. In step i, bank b is asked for column (`op2_col` + i) when its selector b mod (NBANK/N) equals `op2_sel` and differs from `op1_sel`, and for (`op1_col` + i) otherwise. n = 0 does nothing.
- R7: Active units whose `cmd_mask` bit is 0 hold their accumulators.
- R8: A move with `mv_load` = 0 writes each masked unit's accumulator into its local-buffer entry `mv_addr`. With `mv_load` = 1 it loads that entry into the accumulator.
- R9: A command whose unit count is not in the allowed set (`MODE_MASK` bit k allows NBANK>>k), or whose selector is not below NBANK/N, raises `err` for one cycle in the next cycle and changes no state.
- R10: Moves act only when the block is idle and no command is presented in the same cycle; a command presented together with a move wins and the move is dropped; commands and moves that arrive while `busy` is high are ignored.
- R11: A fill with `fill_global` = 1 writes `fill_data` to global-buffer entry `fill_addr`. With `fill_global` = 0 it writes the data, zero-extended, into entry `fill_addr` of every local buffer whose `fill_mask` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Compute command present |
| cmd_units | input | BW+1 | Number of active units |
| cmd_mask | input | NBANK | Per-unit compute enable |
| op1_sel | input | BW | Bank selector of the first operand |
| op1_col | input | CW | Starting column of the first operand |
| op2_sel | input | BW | Bank selector of the second operand |
| op2_row | input | RW | Row field of the second operand (zero picks the local buffer) |
| op2_col | input | CW | Starting column or buffer offset of the second operand |
| cmd_ncol | input | NW | Number of consecutive columns |
| mv_valid | input | 1 | Register move present |
| mv_load | input | 1 | 1: buffer to accumulator, 0: accumulator to buffer |
| mv_mask | input | NBANK | Units taking part in the move |
| mv_addr | input | BA | Local-buffer entry of the move |
| fill_valid | input | 1 | Buffer fill present |
| fill_global | input | 1 | 1: global buffer, 0: local buffers |
| fill_mask | input | NBANK | Local buffers written by the fill |
| fill_addr | input | BA | Buffer entry written by the fill |
| fill_data | input | COLW | Fill word |
| bank_data | input | NBANK*COLW | Column word of bank b at bits [COLW·b +: COLW] |
| bank_col | output | NBANK*CW | Column wanted from bank b at bits [CW·b +: CW] |
| acc_out | output | NBANK*AW | Accumulator of unit u at bits [AW·u +: AW] |
| busy | output | 1 | Command in progress |
| err | output | 1 | One-cycle pulse for a rejected command |

## Verification
Three things can fall in the same idle cycle: a valid compute command, a register move and a fill. The command-against-move race is provoked by raising both valids on one edge, with the move aimed at loading a nonzero buffer entry into every accumulator. After the command completes, every accumulator must equal the value predicted from the compute alone. A second command and move are also presented mid-run, and the same final values prove that both were ignored.

// File: rtl/nbmac_pkg.sv
package nbmac_pkg;
   typedef enum logic [1:0] {
      SRC_BANK   = 2'd0,
      SRC_LOCAL  = 2'd1,
      SRC_GLOBAL = 2'd2
   } op2_src_e;
endpackage

// File: rtl/nbmac_decode.sv
module nbmac_decode
   import nbmac_pkg::*;
#(
   parameter int NBANK     = 8,
   parameter int MODE_MASK = 'b0011,
   parameter int RW        = 4,
   localparam int BW  = $clog2(NBANK),
   localparam int UCW = BW + 1,
   localparam int SW  = $clog2(BW + 1)
) (
   input  logic [UCW-1:0] units,
   input  logic [BW-1:0]  sel1,
   input  logic [BW-1:0]  sel2,
   input  logic [RW-1:0]  row2,
   output logic           ok,
   output logic [SW-1:0]  shift,
   output op2_src_e       src
);
   logic found;

   always_comb begin
      found = 1'b0;
      shift = '0;
      for (int k = 0; k <= BW; k++) begin
         if (MODE_MASK[k] && units == UCW'(NBANK >> k)) begin
            found = 1'b1;
            shift = SW'(k);
         end
      end
      ok = found && ((sel1 >> shift) == '0) && ((sel2 >> shift) == '0);
   end

   always_comb begin
      if (sel1 != sel2)      src = SRC_BANK;
      else if (row2 == '0)   src = SRC_LOCAL;
      else                   src = SRC_GLOBAL;
   end
endmodule

// File: rtl/nbmac_gbuf.sv
module nbmac_gbuf #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 32,
   localparam int BA = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [BA-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [BA-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_data
);
   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
      end else if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   assign rd_data = mem[rd_addr];

   a_r11_gb_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/nbmac_unit.sv
module nbmac_unit
   import nbmac_pkg::*;
#(
   parameter int DW        = 8,
   parameter int LANES     = 4,
   parameter int AW        = 32,
   parameter int BUF_DEPTH = 8,
   localparam int COLW = DW * LANES,
   localparam int BA   = $clog2(BUF_DEPTH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            comp_en,
   input  logic [COLW-1:0] a_word,
   input  logic [COLW-1:0] b_bank,
   input  logic [COLW-1:0] b_glob,
   input  op2_src_e        src,
   input  logic [BA-1:0]   rd_addr,
   input  logic            ld_en,
   input  logic            st_en,
   input  logic [BA-1:0]   mv_addr,
   input  logic            fill_en,
   input  logic [BA-1:0]   fill_addr,
   input  logic [COLW-1:0] fill_data,
   output logic [AW-1:0]   acc
);
   logic [AW-1:0]   acc_q;
   logic [AW-1:0]   lb [BUF_DEPTH];
   logic [COLW-1:0] b_word;
   logic [AW-1:0]   lane_sum;

   function automatic logic [AW-1:0] dotp(input logic [COLW-1:0] a,
                                          input logic [COLW-1:0] b);
      logic signed [AW-1:0]   s;
      logic signed [DW-1:0]   x;
      logic signed [DW-1:0]   y;
      logic signed [2*DW-1:0] p;
      s = '0;
      for (int j = 0; j < LANES; j++) begin
         x = a[j*DW +: DW];
         y = b[j*DW +: DW];
         p = x * y;
         s = s + AW'(p);
      end
      return s;
   endfunction

   always_comb begin
      case (src)
         SRC_BANK:  b_word = b_bank;
         SRC_LOCAL: b_word = lb[rd_addr][COLW-1:0];
         default:   b_word = b_glob;
      endcase
   end

   assign lane_sum = dotp(a_word, b_word);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         acc_q <= '0;
      else if (comp_en)   acc_q <= acc_q + lane_sum;
      else if (ld_en)     acc_q <= lb[mv_addr];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int a = 0; a < BUF_DEPTH; a++) lb[a] <= '0;
      end else if (st_en) begin
         lb[mv_addr] <= acc_q;
      end else if (fill_en) begin
         lb[fill_addr] <= AW'(fill_data);
      end
   end

   assign acc = acc_q;

   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!comp_en && !ld_en) |=> $stable(acc_q));
   a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
      comp_en |-> !(ld_en || st_en));
   a_r8_store: assert property (@(posedge clk) disable iff (!rst_n)
      st_en |=> lb[$past(mv_addr)] == $past(acc_q));
endmodule

// File: rtl/nbmac_array.sv
module nbmac_array
   import nbmac_pkg::*;
#(
   parameter int NBANK     = 8,
   parameter int MODE_MASK = 'b0011,
   parameter int DW        = 8,
   parameter int LANES     = 4,
   parameter int AW        = 32,
   parameter int BUF_DEPTH = 8,
   parameter int CW        = 5,
   parameter int RW        = 4,
   parameter int NW        = 5,
   localparam int BW   = $clog2(NBANK),
   localparam int UCW  = BW + 1,
   localparam int SW   = $clog2(BW + 1),
   localparam int COLW = DW * LANES,
   localparam int BA   = $clog2(BUF_DEPTH)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_valid,
   input  logic [UCW-1:0]        cmd_units,
   input  logic [NBANK-1:0]      cmd_mask,
   input  logic [BW-1:0]         op1_sel,
   input  logic [CW-1:0]         op1_col,
   input  logic [BW-1:0]         op2_sel,
   input  logic [RW-1:0]         op2_row,
   input  logic [CW-1:0]         op2_col,
   input  logic [NW-1:0]         cmd_ncol,
   input  logic                  mv_valid,
   input  logic                  mv_load,
   input  logic [NBANK-1:0]      mv_mask,
   input  logic [BA-1:0]         mv_addr,
   input  logic                  fill_valid,
   input  logic                  fill_global,
   input  logic [NBANK-1:0]      fill_mask,
   input  logic [BA-1:0]         fill_addr,
   input  logic [COLW-1:0]       fill_data,
   input  logic [NBANK*COLW-1:0] bank_data,
   output logic [NBANK*CW-1:0]   bank_col,
   output logic [NBANK*AW-1:0]   acc_out,
   output logic                  busy,
   output logic                  err
);
   // elaboration-time parameter checks
   if ((1 << BW) != NBANK || NBANK < 2) begin : g_bad_nbank
      initial $fatal(1, "NBANK must be a power of two of at least 2");
   end
   if ((1 << BA) != BUF_DEPTH) begin : g_bad_depth
      initial $fatal(1, "BUF_DEPTH must be a power of two");
   end
   if (AW < 2*DW + $clog2(LANES) || AW < COLW) begin : g_bad_aw
      initial $fatal(1, "AW too narrow for the lane sum or a column word");
   end
   if ((MODE_MASK & ((1 << (BW + 1)) - 1)) == 0) begin : g_bad_modes
      initial $fatal(1, "MODE_MASK allows no unit count");
   end

   logic           dec_ok;
   logic [SW-1:0]  dec_shift;
   op2_src_e       dec_src;

   nbmac_decode #(.NBANK(NBANK), .MODE_MASK(MODE_MASK), .RW(RW)) u_dec (
      .units(cmd_units), .sel1(op1_sel), .sel2(op2_sel), .row2(op2_row),
      .ok(dec_ok), .shift(dec_shift), .src(dec_src)
   );

   logic             busy_q, err_q;
   logic [NW-1:0]    left_q, idx_q;
   logic [SW-1:0]    l_shift;
   logic [BW-1:0]    l_sel1, l_sel2;
   logic [CW-1:0]    l_col1, l_col2;
   op2_src_e         l_src;
   logic [NBANK-1:0] l_mask;
   logic [NBANK-1:0] act_mask;
   logic             accept, reject, mv_go;

   always_comb begin
      for (int u = 0; u < NBANK; u++) act_mask[u] = (UCW'(u) < cmd_units);
   end

   assign accept = cmd_valid && !busy_q && dec_ok && (cmd_ncol != '0);
   assign reject = cmd_valid && !busy_q && !dec_ok;
   assign mv_go  = mv_valid && !busy_q && !cmd_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         err_q   <= 1'b0;
         left_q  <= '0;
         idx_q   <= '0;
         l_shift <= '0;
         l_sel1  <= '0;
         l_sel2  <= '0;
         l_col1  <= '0;
         l_col2  <= '0;
         l_src   <= SRC_BANK;
         l_mask  <= '0;
      end else begin
         err_q <= reject;
         if (accept) begin
            busy_q  <= 1'b1;
            left_q  <= cmd_ncol;
            idx_q   <= '0;
            l_shift <= dec_shift;
            l_sel1  <= op1_sel;
            l_sel2  <= op2_sel;
            l_col1  <= op1_col;
            l_col2  <= op2_col;
            l_src   <= dec_src;
            l_mask  <= cmd_mask & act_mask;
         end else if (busy_q) begin
            idx_q  <= idx_q + 1'b1;
            left_q <= left_q - 1'b1;
            if (left_q == NW'(1)) busy_q <= 1'b0;
         end
      end
   end

   logic [CW-1:0] cur1, cur2;
   logic [BW-1:0] fan_m;
   assign cur1  = l_col1 + CW'(idx_q);
   assign cur2  = l_col2 + CW'(idx_q);
   assign fan_m = BW'((1 << l_shift) - 1);

   for (genvar b = 0; b < NBANK; b++) begin : g_col
      logic [BW-1:0] bsel;
      assign bsel = BW'(b) & fan_m;
      assign bank_col[b*CW +: CW] =
         (bsel == l_sel2 && l_sel2 != l_sel1) ? cur2 : cur1;
   end

   logic [COLW-1:0] gb_word;

   nbmac_gbuf #(.DEPTH(BUF_DEPTH), .WIDTH(COLW)) u_gb (
      .clk(clk), .rst_n(rst_n),
      .wr_en(fill_valid && fill_global), .wr_addr(fill_addr), .wr_data(fill_data),
      .rd_addr(cur2[BA-1:0]), .rd_data(gb_word)
   );

   for (genvar u = 0; u < NBANK; u++) begin : g_unit
      logic [BW-1:0] ib1, ib2;
      assign ib1 = BW'(u << l_shift) | l_sel1;
      assign ib2 = BW'(u << l_shift) | l_sel2;

      nbmac_unit #(.DW(DW), .LANES(LANES), .AW(AW), .BUF_DEPTH(BUF_DEPTH)) u_pu (
         .clk(clk), .rst_n(rst_n),
         .comp_en(busy_q && l_mask[u]),
         .a_word(bank_data[ib1*COLW +: COLW]),
         .b_bank(bank_data[ib2*COLW +: COLW]),
         .b_glob(gb_word),
         .src(l_src),
         .rd_addr(cur2[BA-1:0]),
         .ld_en(mv_go && mv_load && mv_mask[u]),
         .st_en(mv_go && !mv_load && mv_mask[u]),
         .mv_addr(mv_addr),
         .fill_en(fill_valid && !fill_global && fill_mask[u]),
         .fill_addr(fill_addr),
         .fill_data(fill_data),
         .acc(acc_out[u*AW +: AW])
      );
   end

   assign busy = busy_q;
   assign err  = err_q;

   a_r6_last: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && left_q == NW'(1)) |=> !busy_q);
   a_r6_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> idx_q == '0);
   a_r9_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> !busy_q);
   a_r2_inactive: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (l_mask >> (NBANK >> l_shift)) == '0);
   a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && left_q != NW'(1)) |=> busy_q && $stable(l_mask));
endmodule

// File: tb/sim_nbmac_array.sv
`timescale 1ns/1ps
module sim_nbmac_array;
   localparam int NB = 8, AW = 32, CWW = 5, COLW = 32, BD = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          cmd_valid = 0, mv_valid = 0, mv_load = 0, fill_valid = 0, fill_global = 0;
   logic [3:0]    cmd_units = 0, op2_row = 0;
   logic [7:0]    cmd_mask = 0, mv_mask = 0, fill_mask = 0;
   logic [2:0]    op1_sel = 0, op2_sel = 0, mv_addr = 0, fill_addr = 0;
   logic [4:0]    op1_col = 0, op2_col = 0, cmd_ncol = 0;
   logic [31:0]   fill_data = 0;
   logic [NB*COLW-1:0] bank_data;
   logic [NB*CWW-1:0]  bank_col;
   logic [NB*AW-1:0]   acc_out;
   logic busy, err;

   nbmac_array u0 (.*);

   int n_run = 0, n_fail = 0;
   logic signed [31:0] e_acc [NB];
   logic [31:0] e_lb [NB][BD];
   logic [31:0] e_gb [BD];

   function automatic logic [31:0] bword(int b, int c);
      logic [31:0] w;
      for (int j = 0; j < 4; j++) w[j*8 +: 8] = 8'((b*29 + c*13 + j*7 + 5) ^ (j*45));
      return w;
   endfunction
   function automatic logic [31:0] gpat(int a);
      logic [31:0] w;
      for (int j = 0; j < 4; j++) w[j*8 +: 8] = 8'(a*19 + j*23 + 129);
      return w;
   endfunction
   function automatic logic [31:0] lpat(int u, int a);
      logic [31:0] w;
      for (int j = 0; j < 4; j++) w[j*8 +: 8] = 8'(u*31 + a*17 + j*11 + 9);
      return w;
   endfunction
   function automatic logic signed [31:0] dot(logic [31:0] a, logic [31:0] b);
      int s = 0;
      for (int j = 0; j < 4; j++) begin
         int x = $signed(a[j*8 +: 8]);
         int y = $signed(b[j*8 +: 8]);
         s += x * y;
      end
      return s;
   endfunction

   always_comb begin
      for (int b = 0; b < NB; b++) bank_data[b*32 +: 32] = bword(b, int'(bank_col[b*5 +: 5]));
   end

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic chk_accs(string req);
      for (int u = 0; u < NB; u++)
         chk(acc_out[u*32 +: 32] == e_acc[u], req, $sformatf("acc[%0d]", u),
             longint'($signed(acc_out[u*32 +: 32])), longint'(e_acc[u]));
   endtask

   typedef struct packed {
      logic [3:0] units; logic [7:0] mask; logic [2:0] s1, s2;
      logic [3:0] row; logic [4:0] c1, c2, n;
   } vec_t;

   // units, mask, sel1, sel2, row2, col1, col2, ncol
   localparam vec_t VEC [0:6] = '{
      '{4'd8, 8'hFF, 3'd0, 3'd0, 4'd0, 5'd2,  5'd1, 5'd3},  // R4 local buffer
      '{4'd8, 8'hA5, 3'd0, 3'd0, 4'd3, 5'd0,  5'd5, 5'd4},  // R5 global, R7 mask
      '{4'd4, 8'hFF, 3'd0, 3'd1, 4'd0, 5'd4,  5'd9, 5'd5},  // R3 banks, R2 fan 2
      '{4'd4, 8'h0B, 3'd1, 3'd0, 4'd1, 5'd1,  5'd3, 5'd2},  // R3 swapped
      '{4'd4, 8'h0F, 3'd1, 3'd1, 4'd0, 5'd7,  5'd6, 5'd3},  // R4 fan 2
      '{4'd4, 8'h06, 3'd1, 3'd1, 4'd2, 5'd10, 5'd2, 5'd2},  // R5 fan 2
      '{4'd8, 8'hFF, 3'd0, 3'd0, 4'd0, 5'd0,  5'd0, 5'd0}   // R6 zero columns
   };

   task automatic model_cmd(vec_t v);
      int fan = NB / int'(v.units);
      for (int u = 0; u < int'(v.units); u++) begin
         if (v.mask[u]) begin
            for (int i = 0; i < int'(v.n); i++) begin
               logic [31:0] a, b;
               a = bword(u*fan + int'(v.s1), (int'(v.c1) + i) % 32);
               if (v.s1 != v.s2)       b = bword(u*fan + int'(v.s2), (int'(v.c2) + i) % 32);
               else if (v.row == 0)    b = e_lb[u][(int'(v.c2) + i) % BD];
               else                    b = e_gb[(int'(v.c2) + i) % BD];
               e_acc[u] += dot(a, b);
            end
         end
      end
   endtask

   task automatic put_cmd(vec_t v);
      cmd_units = v.units; cmd_mask = v.mask; op1_sel = v.s1; op2_sel = v.s2;
      op2_row = v.row; op1_col = v.c1; op2_col = v.c2; cmd_ncol = v.n;
      cmd_valid = 1'b1;
   endtask

   task automatic wait_idle(output int cyc);
      cyc = 0;
      while (busy && cyc < 100) begin cyc++; @(posedge clk); #1; end
   endtask

   task automatic run_vec(vec_t v, string req);
      int cyc, fan, sel, expc;
      model_cmd(v);
      put_cmd(v);
      @(posedge clk); #1;
      cmd_valid = 1'b0;
      if (v.n != 0) begin
         fan = NB / int'(v.units);
         sel = 1 % fan;
         expc = (sel == int'(v.s2) && v.s2 != v.s1) ? int'(v.c2) : int'(v.c1);
         chk(bank_col[5 +: 5] == 5'(expc), "R6", "bank_col[1] step 0",
             longint'(bank_col[5 +: 5]), longint'(expc));
      end
      wait_idle(cyc);
      chk(cyc == int'(v.n), "R6", "busy cycles", cyc, v.n);
      chk_accs(req);
   endtask

   task automatic do_fill(bit glob, logic [7:0] m, int a, logic [31:0] d);
      fill_valid = 1; fill_global = glob; fill_mask = m; fill_addr = 3'(a); fill_data = d;
      @(posedge clk); #1;
      fill_valid = 0;
   endtask

   task automatic reject(vec_t v);
      put_cmd(v);
      @(posedge clk); #1;
      cmd_valid = 0;
      chk(err == 1'b1, "R9", "err pulse", err, 1);
      chk(busy == 1'b0, "R9", "busy after reject", busy, 0);
      @(posedge clk); #1;
      chk(err == 1'b0, "R9", "err clears", err, 0);
      chk_accs("R9");
   endtask

   bit done = 0;
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++; n_run++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int cyc;
      vec_t w;
      for (int u = 0; u < NB; u++) begin
         e_acc[u] = 0;
         for (int a = 0; a < BD; a++) e_lb[u][a] = 0;
      end
      for (int a = 0; a < BD; a++) e_gb[a] = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      // R1 reset state
      chk_accs("R1");
      chk(busy == 0, "R1", "busy", busy, 0);
      chk(err == 0, "R1", "err", err, 0);

      // R11 fills: global and per-unit local buffers
      for (int a = 0; a < BD; a++) begin
         do_fill(1'b1, 8'h00, a, gpat(a));
         e_gb[a] = gpat(a);
      end
      for (int u = 0; u < NB; u++)
         for (int a = 0; a < BD; a++) begin
            do_fill(1'b0, 8'(1 << u), a, lpat(u, a));
            e_lb[u][a] = lpat(u, a);
         end

      // table walk: R2 R3 R4 R5 R6 R7 R11
      for (int k = 0; k < 7; k++) run_vec(VEC[k], $sformatf("R2/R3/R4/R5/R7/R11 vec%0d", k));

      // R9 rejected commands
      reject('{4'd2, 8'hFF, 3'd0, 3'd0, 4'd0, 5'd0, 5'd0, 5'd2});
      reject('{4'd4, 8'hFF, 3'd0, 3'd2, 4'd0, 5'd0, 5'd0, 5'd2});
      reject('{4'd8, 8'hFF, 3'd1, 3'd0, 4'd0, 5'd0, 5'd0, 5'd2});
      reject('{4'd5, 8'hFF, 3'd0, 3'd0, 4'd0, 5'd0, 5'd0, 5'd2});

      // R8 store accumulators to entry 6, prove by computing from it
      mv_valid = 1; mv_load = 0; mv_mask = 8'hFF; mv_addr = 3'd6;
      @(posedge clk); #1;
      mv_valid = 0;
      for (int u = 0; u < NB; u++) e_lb[u][6] = e_acc[u];
      chk_accs("R8 store leaves acc");
      run_vec('{4'd8, 8'hFF, 3'd0, 3'd0, 4'd0, 5'd3, 5'd6, 5'd1}, "R8 store");
      // R8 load back into units 0..3
      mv_valid = 1; mv_load = 1; mv_mask = 8'h0F; mv_addr = 3'd6;
      @(posedge clk); #1;
      mv_valid = 0;
      for (int u = 0; u < 4; u++) e_acc[u] = e_lb[u][6];
      chk_accs("R8 load");

      // R10 command and move in the same idle cycle; then both again while busy
      w = '{4'd4, 8'hFF, 3'd0, 3'd1, 4'd0, 5'd3, 5'd8, 5'd4};
      model_cmd(w);
      put_cmd(w);
      mv_valid = 1; mv_load = 1; mv_mask = 8'hFF; mv_addr = 3'd2;
      @(posedge clk); #1;
      chk(busy == 1, "R10", "command accepted over move", busy, 1);
      put_cmd('{4'd8, 8'hFF, 3'd0, 3'd0, 4'd2, 5'd0, 5'd0, 5'd3});
      @(posedge clk); #1;
      cmd_valid = 0; mv_valid = 0;
      wait_idle(cyc);
      chk(cyc == 3, "R10", "remaining busy cycles", cyc, 3);
      chk_accs("R10");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule